// File: doc/BRIEF.md
# Register-Mapped GPIO Block with Grouped Interrupts

This block gives software control over up to 32 general-purpose pins through a small single-cycle register bus. Every pin can be set as an input or as an output. An output drives either a stored level or, when its blink bit is set, a square wave taken from one shared free-running divider. Each incoming pin level passes through a two-flop synchronizer and then a per-pin polarity XOR. The result is the pin's "active" value, readable as the data-in register.

Each pin feeds two interrupt sources from its active value. The level source is the active value gated by a level mask, and it holds no state. The edge source is a sticky cause bit. It is set when the active value goes from inactive to active, and software clears it by writing zeros. Gated by an edge mask, the edge source is ORed with the level source to form the pin's pending term. Pending terms are then ORed in groups of eight consecutive pins to drive one summary interrupt line per group.

Top module: `gpio_agg_top`

## Requirements
- R1: After reset the direction register reads all ones (every pin an input) and every other register reads zero, `pin_oe` and `pin_out` are zero, and `irq_sum` is zero.
- R2: Registers sit at byte addresses: output level 0x00, direction 0x04, blink enable 0x08, polarity 0x0C, data-in 0x10, edge cause 0x14. The edge mask is at 0x18 + MASK_OFS and the level mask at 0x1C + MASK_OFS. The output, direction, blink, polarity and both mask registers read back what was written. An address that decodes to nothing has no effect.
- R3: Direction bit 1 makes a pin an input, with `pin_oe` low and `pin_out` low. Direction bit 0 sets `pin_oe` high, and `pin_out` follows the output-level bit whenever blink is clear.
- R4: Data-in bit i equals pin_in[i] XOR polarity bit i. A pin change shows up two clock edges later, and a polarity change shows up at once. Writes to data-in are ignored.
- R5: A pin's level term is its data-in bit AND its level-mask bit. It is not latched and drops as soon as the data-in bit goes inactive.
- R6: The edge-cause bit of a pin is set on the clock edge after its data-in bit goes from 0 to 1: a rising pin with polarity 0, a falling pin with polarity 1. It stays set when the input returns.
- R7: A write to the edge-cause register ANDs the written data into it: a 0 clears that bit and a 1 leaves it unchanged.
- R8: When an edge and a cause-clearing write land on the same clock edge, the cause bit ends up set.
- R9: The edge term is the cause bit AND the edge-mask bit. Cause bits latch even while masked.
- R10: irq_sum[g] is the OR of the pending terms of pins 8g to 8g+7, and no other pin affects it.
- R11: An output pin whose blink bit is set toggles `pin_out` every BLINK_HALF clock cycles, whatever its output-level bit holds.
- R12: A blink bit on an input pin has no effect, and its `pin_out` stays low.
- R13: Writing zero to the edge cause, edge mask and level mask registers drops every summary line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Raw asynchronous pin levels |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Output enables, 1 = driving |
| irq_sum | output | NPINS/8 | Per-group summary interrupts |

## Verification
On every cycle the checker enforces several properties. Input pins never drive a value, and non-blinking outputs track their level register. Any unmasked level or edge term forces a summary line high, and with both masks clear every line is low. A detected edge is always captured in the cause register, and cause bits can fall only after a write to that register. The exact two-edge synchronizer latency, the read-modify behaviour of cause writes, the same-edge race between clear and edge, the shifted mask addresses, the group boundaries and the blink period can only be shown by the bench's timed scenarios.

// File: rtl/gpio_agg_pkg.sv
package gpio_agg_pkg;

   localparam int unsigned OFS_OUT   = 32'h00;
   localparam int unsigned OFS_DIR   = 32'h04;
   localparam int unsigned OFS_BLINK = 32'h08;
   localparam int unsigned OFS_POL   = 32'h0C;
   localparam int unsigned OFS_DIN   = 32'h10;
   localparam int unsigned OFS_CAUSE = 32'h14;
   localparam int unsigned OFS_EMASK = 32'h18;
   localparam int unsigned OFS_LMASK = 32'h1C;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_OUT,
      SEL_DIR,
      SEL_BLINK,
      SEL_POL,
      SEL_DIN,
      SEL_CAUSE,
      SEL_EMASK,
      SEL_LMASK
   } reg_sel_e;

endpackage

// File: rtl/gpio_agg_decode.sv
module gpio_agg_decode
   import gpio_agg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned MASK_OFS = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
   localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'(OFS_BLINK);
   localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
   localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);
   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
   localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(OFS_EMASK + MASK_OFS);
   localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(OFS_LMASK + MASK_OFS);

   generate
      if ((MASK_OFS % 4) != 0) begin : g_bad_align
         $error("MASK_OFS must be a multiple of four");
      end
      if ((OFS_LMASK + MASK_OFS) >= (2 ** ADDR_W)) begin : g_bad_range
         $error("mask registers do not fit in ADDR_W address bits");
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if (addr == A_OUT)        sel = SEL_OUT;
      else if (addr == A_DIR)   sel = SEL_DIR;
      else if (addr == A_BLINK) sel = SEL_BLINK;
      else if (addr == A_POL)   sel = SEL_POL;
      else if (addr == A_DIN)   sel = SEL_DIN;
      else if (addr == A_CAUSE) sel = SEL_CAUSE;
      else if (addr == A_EMASK) sel = SEL_EMASK;
      else if (addr == A_LMASK) sel = SEL_LMASK;
   end

endmodule

// File: rtl/gpio_agg_sync.sv
module gpio_agg_sync #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic [NPINS-1:0] pol,
   output logic [NPINS-1:0] din,
   output logic [NPINS-1:0] din_prev
);

   genvar i;
   generate
      for (i = 0; i < NPINS; i++) begin : g_pin
         logic meta_q;
         logic stab_q;
         logic prev_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               meta_q <= 1'b0;
               stab_q <= 1'b0;
               prev_q <= 1'b0;
            end else begin
               meta_q <= pin_in[i];
               stab_q <= meta_q;
               prev_q <= din[i];
            end
         end

         assign din[i]      = stab_q ^ pol[i];
         assign din_prev[i] = prev_q;
      end
   endgenerate

endmodule

// File: rtl/gpio_agg_blink.sv
module gpio_agg_blink #(
   parameter int unsigned BLINK_HALF = 1024
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);

   localparam int unsigned CW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

   generate
      if (BLINK_HALF < 1) begin : g_bad_half
         $error("BLINK_HALF must be at least one");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/gpio_agg_irq.sv
module gpio_agg_irq #(
   parameter int unsigned NPINS = 32,
   parameter int unsigned GROUP = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPINS-1:0]       din,
   input  logic [NPINS-1:0]       din_prev,
   input  logic                   cause_wr,
   input  logic [NPINS-1:0]       wdata,
   input  logic [NPINS-1:0]       emask,
   input  logic [NPINS-1:0]       lmask,
   output logic [NPINS-1:0]       cause,
   output logic [NPINS/GROUP-1:0] irq_sum
);

   localparam int unsigned NGRP = NPINS / GROUP;

   logic [NPINS-1:0] cause_q;
   logic [NPINS-1:0] cause_nx;
   logic [NPINS-1:0] rise;
   logic [NPINS-1:0] pend;

   assign rise = din & ~din_prev;

   always_comb begin
      cause_nx = cause_q;
      if (cause_wr) cause_nx = cause_q & wdata;
      cause_nx = cause_nx | rise;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= cause_nx;
   end

   assign pend  = (din & lmask) | (cause_q & emask);
   assign cause = cause_q;

   genvar g;
   generate
      for (g = 0; g < NGRP; g++) begin : g_grp
         assign irq_sum[g] = |pend[g*GROUP +: GROUP];
      end
   endgenerate

endmodule

// File: rtl/gpio_agg_top.sv
module gpio_agg_top
   import gpio_agg_pkg::*;
#(
   parameter int unsigned NPINS      = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned MASK_OFS   = 0,
   parameter int unsigned BLINK_HALF = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS/8-1:0] irq_sum
);

   localparam int unsigned GROUP = 8;
   localparam int unsigned NGRP  = NPINS / GROUP;

   generate
      if (NPINS > 32 || NPINS < GROUP) begin : g_bad_npins
         $error("NPINS must lie between 8 and 32");
      end
      if ((NPINS % GROUP) != 0) begin : g_bad_groups
         $error("NPINS must be a whole number of eight-pin groups");
      end
   endgenerate

   reg_sel_e         sel;
   logic [NPINS-1:0] wdat;
   logic [NPINS-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
   logic [NPINS-1:0] din, din_prev, cause_q;
   logic             cause_wr;
   logic             phase;

   assign wdat     = bus_wdata[NPINS-1:0];
   assign cause_wr = bus_we && (sel == SEL_CAUSE);

   gpio_agg_decode #(
      .ADDR_W   (ADDR_W),
      .MASK_OFS (MASK_OFS)
   ) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q   <= '0;
         dir_q   <= '1;
         blink_q <= '0;
         pol_q   <= '0;
         emask_q <= '0;
         lmask_q <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_OUT:   out_q   <= wdat;
            SEL_DIR:   dir_q   <= wdat;
            SEL_BLINK: blink_q <= wdat;
            SEL_POL:   pol_q   <= wdat;
            SEL_EMASK: emask_q <= wdat;
            SEL_LMASK: lmask_q <= wdat;
            default: ;
         endcase
      end
   end

   gpio_agg_sync #(
      .NPINS (NPINS)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .pol      (pol_q),
      .din      (din),
      .din_prev (din_prev)
   );

   gpio_agg_irq #(
      .NPINS (NPINS),
      .GROUP (GROUP)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (din),
      .din_prev (din_prev),
      .cause_wr (cause_wr),
      .wdata    (wdat),
      .emask    (emask_q),
      .lmask    (lmask_q),
      .cause    (cause_q),
      .irq_sum  (irq_sum)
   );

   gpio_agg_blink #(
      .BLINK_HALF (BLINK_HALF)
   ) u_blink (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   genvar i;
   generate
      for (i = 0; i < NPINS; i++) begin : g_drv
         assign pin_oe[i]  = ~dir_q[i];
         assign pin_out[i] = dir_q[i] ? 1'b0 : (blink_q[i] ? phase : out_q[i]);
      end
   endgenerate

   function automatic logic [31:0] widen(input logic [NPINS-1:0] v);
      logic [31:0] r;
      r = '0;
      r[NPINS-1:0] = v;
      return r;
   endfunction

   always_comb begin
      case (sel)
         SEL_OUT:   bus_rdata = widen(out_q);
         SEL_DIR:   bus_rdata = widen(dir_q);
         SEL_BLINK: bus_rdata = widen(blink_q);
         SEL_POL:   bus_rdata = widen(pol_q);
         SEL_DIN:   bus_rdata = widen(din);
         SEL_CAUSE: bus_rdata = widen(cause_q);
         SEL_EMASK: bus_rdata = widen(emask_q);
         SEL_LMASK: bus_rdata = widen(lmask_q);
         default:   bus_rdata = '0;
      endcase
   end

   if (NGRP == 0) begin : g_never
      $error("no interrupt groups");
   end

endmodule

// File: rtl/gpio_agg_chk.sv
module gpio_agg_chk #(
   parameter int unsigned NPINS = 32,
   parameter int unsigned NGRP  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] pin_oe,
   input logic [NGRP-1:0]  irq_sum,
   input logic [NPINS-1:0] out_q,
   input logic [NPINS-1:0] blink_q,
   input logic [NPINS-1:0] din,
   input logic [NPINS-1:0] din_prev,
   input logic [NPINS-1:0] cause_q,
   input logic             cause_wr,
   input logic [NPINS-1:0] emask_q,
   input logic [NPINS-1:0] lmask_q
);

   logic [NPINS-1:0] edge_v;
   assign edge_v = din & ~din_prev;

   p_in_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   p_out_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out ^ out_q) & pin_oe & ~blink_q) == '0);

   p_level_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((din & lmask_q) != '0) |-> (irq_sum != '0));

   p_edge_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_q & emask_q) != '0) |-> (irq_sum != '0));

   p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (emask_q == '0 && lmask_q == '0) |-> (irq_sum == '0));

   // R6 and R8: an edge is always captured, even against a clearing write
   p_edge_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_v != '0) |=> ((cause_q & $past(edge_v)) == $past(edge_v)));

   p_cause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

endmodule

bind gpio_agg_top gpio_agg_chk #(
   .NPINS (NPINS),
   .NGRP  (NGRP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .irq_sum  (irq_sum),
   .out_q    (out_q),
   .blink_q  (blink_q),
   .din      (din),
   .din_prev (din_prev),
   .cause_q  (cause_q),
   .cause_wr (cause_wr),
   .emask_q  (emask_q),
   .lmask_q  (lmask_q)
);

// File: tb/gpio_agg_top_tb_top.sv
module gpio_agg_top_tb_top;

   localparam int unsigned NPINS  = 32;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned MOFS   = 32'h20;
   localparam int unsigned HALF   = 8;

   localparam logic [7:0] A_OUT = 8'h00, A_DIR = 8'h04, A_BLK = 8'h08, A_POL = 8'h0C;
   localparam logic [7:0] A_DIN = 8'h10, A_CAU = 8'h14;
   localparam logic [7:0] A_EM  = 8'h38, A_LM = 8'h3C;

   localparam int K_RD = 0, K_IRQ = 1, K_OUT = 2, K_OE = 3, K_VAL = 4;

   typedef struct {
      int          kind;
      logic [31:0] act;
      logic [31:0] exp;
      string       req;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_we = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NPINS-1:0]  pin_in = '0;
   logic [NPINS-1:0]  pin_out;
   logic [NPINS-1:0]  pin_oe;
   logic [3:0]        irq_sum;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   item_t q[$];
   event  mon_ev;

   always #4 clk = ~clk;

   gpio_agg_top #(
      .NPINS      (NPINS),
      .ADDR_W     (ADDR_W),
      .MASK_OFS   (MOFS),
      .BLINK_HALF (HALF)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq_sum   (irq_sum)
   );

   // monitor: pops each expected item and compares it with the design
   initial begin
      forever begin
         @(mon_ev);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] a;
            it = q.pop_front();
            case (it.kind)
               K_RD:    a = bus_rdata;
               K_IRQ:   a = {28'd0, irq_sum};
               K_OUT:   a = pin_out;
               K_OE:    a = pin_oe;
               default: a = it.act;
            endcase
            n_cmp++;
            if (a !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.req, a, it.exp);
            end
         end
      end
   end

   task automatic push(input int kind, input logic [31:0] act, input logic [31:0] exp,
                       input string req);
      item_t it;
      it.kind = kind; it.act = act; it.exp = exp; it.req = req;
      q.push_back(it);
      #1;
      -> mon_ev;
      #0;
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      push(K_RD, '0, exp, req);
   endtask

   task automatic chk(input int kind, input logic [31:0] exp, input string req);
      push(kind, '0, exp, req);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      #1;
      bus_we    = 1'b0;
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   initial begin
      int tog, hi20, lo1;
      logic p0;
      step(4);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      chk_rd(A_DIR, 32'hFFFF_FFFF, "R1 dir");
      chk_rd(A_OUT, 32'h0, "R1 out");
      chk_rd(A_BLK, 32'h0, "R1 blink");
      chk_rd(A_POL, 32'h0, "R1 pol");
      step(1);
      chk_rd(A_DIN, 32'h0, "R1 din");
      chk_rd(A_CAU, 32'h0, "R1 cause");
      chk_rd(A_EM, 32'h0, "R1 emask");
      chk_rd(A_LM, 32'h0, "R1 lmask");
      step(1);
      chk(K_IRQ, 32'h0, "R1 irq");
      chk(K_OE, 32'h0, "R1 oe");
      chk(K_OUT, 32'h0, "R1 out pins");

      // R2 register map and shifted masks
      wr(A_OUT, 32'hA5A5_0F0F);
      chk_rd(A_OUT, 32'hA5A5_0F0F, "R2 out");
      chk(K_OUT, 32'h0, "R3 inputs do not drive");
      wr(A_EM, 32'h1234_5678);
      chk_rd(A_EM, 32'h1234_5678, "R2 emask");
      wr(8'h18, 32'hFFFF_FFFF);
      chk_rd(A_EM, 32'h1234_5678, "R2 unshifted addr ignored");
      wr(A_EM, 32'h0);
      wr(A_LM, 32'h0F0F_0000);
      chk_rd(A_LM, 32'h0F0F_0000, "R2 lmask");
      wr(A_LM, 32'h0);
      wr(A_BLK, 32'h0000_5555);
      chk_rd(A_BLK, 32'h0000_5555, "R2 blink");
      wr(A_BLK, 32'h0);

      // R3 direction
      wr(A_DIR, 32'hFFFF_0000);
      chk(K_OE, 32'h0000_FFFF, "R3 oe");
      chk(K_OUT, 32'h0000_0F0F, "R3 out follows level");

      // R4 synchronizer latency and polarity
      pin_in = 32'h0030_0000;
      step(1);
      chk_rd(A_DIN, 32'h0, "R4 after one edge");
      step(1);
      chk_rd(A_DIN, 32'h0030_0000, "R4 after two edges");
      wr(A_POL, 32'h0110_0000);
      chk_rd(A_DIN, 32'h0120_0000, "R4 polarity");
      chk_rd(A_POL, 32'h0110_0000, "R2 pol");
      wr(A_DIN, 32'hFFFF_FFFF);
      chk_rd(A_DIN, 32'h0120_0000, "R4 din write ignored");
      wr(A_POL, 32'h0);
      step(2);
      wr(A_CAU, 32'h0);
      chk_rd(A_CAU, 32'h0, "R7 clear all");

      // R5 level source, no latch
      wr(A_LM, 32'h0020_0000);
      chk(K_IRQ, 32'h4, "R5 level active");
      pin_in = 32'h0010_0000;
      step(1);
      chk(K_IRQ, 32'h4, "R5 sync delay");
      step(1);
      chk(K_IRQ, 32'h0, "R5 level drops");
      wr(A_LM, 32'h0);

      // R6 rising edge latch
      pin_in = 32'h0011_0000;
      step(2);
      chk_rd(A_CAU, 32'h0, "R6 not yet latched");
      step(1);
      chk_rd(A_CAU, 32'h0001_0000, "R6 latched");
      pin_in = 32'h0010_0000;
      step(3);
      chk_rd(A_CAU, 32'h0001_0000, "R6 sticky");

      // R6 falling edge with inverted polarity, R7 partial clear
      wr(A_POL, 32'h0002_0000);
      step(2);
      wr(A_CAU, 32'hFFFD_FFFF);
      chk_rd(A_CAU, 32'h0001_0000, "R7 and-write");
      pin_in = 32'h0012_0000;
      step(3);
      chk_rd(A_CAU, 32'h0001_0000, "R6 rise ignored when inverted");
      pin_in = 32'h0010_0000;
      step(3);
      chk_rd(A_CAU, 32'h0003_0000, "R6 falling latched");

      // R9 masking of edge source
      chk(K_IRQ, 32'h0, "R9 masked cause");
      wr(A_EM, 32'h0002_0000);
      chk(K_IRQ, 32'h4, "R9 unmasked cause");

      // R10 grouping
      pin_in = 32'h8010_0008;
      step(3);
      wr(A_LM, 32'h8000_0008);
      chk(K_IRQ, 32'hD, "R10 groups 0 2 3");
      wr(A_EM, 32'h0);
      wr(A_LM, 32'h0000_1000);
      chk(K_IRQ, 32'h0, "R10 idle pin");
      wr(A_LM, 32'h0000_0008);
      chk(K_IRQ, 32'h1, "R10 group 0 only");
      wr(A_LM, 32'h0);

      // R8 edge wins over same-cycle clear
      pin_in = 32'h8014_0008;
      step(2);
      wr(A_CAU, 32'h0);
      chk_rd(A_CAU, 32'h0004_0000, "R8 edge wins");

      // R13 global clear
      wr(A_LM, 32'h8000_0008);
      wr(A_EM, 32'hFFFF_FFFF);
      chk(K_IRQ, 32'hD, "R13 before clear");
      wr(A_CAU, 32'h0);
      wr(A_EM, 32'h0);
      wr(A_LM, 32'h0);
      chk(K_IRQ, 32'h0, "R13 all quiet");
      chk_rd(A_CAU, 32'h0, "R13 cause empty");

      // R11 blink on output, R12 blink on input
      wr(A_BLK, 32'h0010_0001);
      tog = 0; hi20 = 0; lo1 = 0;
      @(negedge clk);
      p0 = pin_out[0];
      for (int s = 0; s < 32; s++) begin
         @(negedge clk);
         if (pin_out[0] != p0) tog++;
         p0 = pin_out[0];
         if (pin_out[20]) hi20++;
         if (!pin_out[1]) lo1++;
      end
      #1;
      push(K_VAL, tog, 32'd4, "R11 toggles in 32 cycles");
      push(K_VAL, hi20, 32'd0, "R12 input blink idle");
      push(K_VAL, lo1, 32'd0, "R3 steady output");
      step(1);
      wr(A_DIR, 32'hFFFF_0001);
      chk(K_OE, 32'h0000_FFFE, "R3 back to input");
      push(K_VAL, {31'd0, pin_out[0]}, 32'd0, "R12 blink bit on input");

      step(2);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule